// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by reading a two-level page table that lives in memory. A requester hands over one virtual address with a valid/ready handshake. The walker latches that address together with the current root-pointer input, which holds the base of the page directory. It then issues word reads on a request/response memory port: first the directory entry, then, when that entry is valid, the page table entry.

The walk ends with a single-cycle completion pulse. The pulse carries either a page fault or the 20-bit frame number and the full physical address, so a translation cache can be filled from it.

Only one walk runs at a time. The request port reports ready only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1, `busy`=0, `done`=0 and `mem_req_valid`=0. No memory read is issued while the walker is idle.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. `req_valid` asserted during a walk has no effect: the walk's result is unchanged and no extra read or walk follows.
- R3: The first read goes to address `{root[31:12], va[31:22], 2'b00}`. This is the page-aligned directory base plus four times the directory index.
- R4: When the directory entry is valid, the second read goes to `{dir_entry[31:12], va[21:12], 2'b00}`.
- R5: In both kinds of entry, bit 0 is the valid bit and bits 31:12 hold the base or frame. A directory entry with bit 0 = 0 ends the walk with `done_fault`=1 after exactly one read, and no second read is issued.
- R6: A page table entry with bit 0 = 0 ends the walk with `done_fault`=1. On a fault, `done_pfn` and `done_paddr` are 0.
- R7: A valid page table entry gives `done_pfn` = `pte[31:12]` and `done_paddr` = `{pte[31:12], va[11:0]}`, with `done_fault`=0. For example, va 0x00403004 uses directory index 1, table index 3 and offset 4.
- R8: Once `mem_req_valid` is raised, it and `mem_req_addr` stay unchanged until a cycle with `mem_req_ready` high.
- R9: The virtual address and the root pointer are captured at acceptance. Later changes on `req_vaddr` or `root_base` do not affect the walk in progress.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. `done` lasts exactly one cycle, and the walker is idle in the cycle after it.
- R11: `mem_rsp_valid` is used only while a read is outstanding. A response pulse at any other time has no effect on the result or on the read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Page directory base (bits 31:12 used) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (table entry) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Page fault flag, valid with done |
| done_pfn | output | 20 | Physical frame number, valid with done |
| done_paddr | output | 32 | Physical address, valid with done |

## Verification
The assertions assume that the memory side answers each accepted read with exactly one `mem_rsp_valid` pulse. They also assume that pulse arrives no earlier than the cycle after the request handshake.

The bench's memory responder keeps to this contract. It records each handshake, waits a random number of cycles and then returns a single response. Stray response pulses are injected only while no read is outstanding.

`mem_req_ready` is randomly withheld. This exercises the hold rule on the request channel without breaking the one-response-per-read contract.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [2:0] {
      S_IDLE     = 3'd0,
      S_DIR_REQ  = 3'd1,
      S_DIR_WAIT = 3'd2,
      S_PTE_REQ  = 3'd3,
      S_PTE_WAIT = 3'd4,
      S_DONE     = 3'd5
   } pgw_state_e;

endpackage

// File: rtl/pgw_entry_addr.sv
// Entry address = page-aligned table base + index * entry size.
module pgw_entry_addr #(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 12,
   parameter int IDX_W     = 10,
   parameter int ENT_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int ENT_SH = $clog2(ENT_BYTES);

   logic [ADDR_W-1:0] aligned_base;
   logic [ADDR_W-1:0] idx_ext;

   assign aligned_base = {base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign idx_ext      = {{(ADDR_W-IDX_W){1'b0}}, idx};

   generate
      if ((1 << ENT_SH) == ENT_BYTES) begin : g_shift
         assign addr = aligned_base + (idx_ext << ENT_SH);
      end else begin : g_mul
         localparam logic [ADDR_W-1:0] ENT_SZ = ADDR_W'(ENT_BYTES);
         assign addr = aligned_base + idx_ext * ENT_SZ;
      end
   endgenerate

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
   import pgw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       mem_req_ready,
   input  logic       mem_rsp_valid,
   input  logic       rsp_entry_ok,
   output pgw_state_e state
);
   pgw_state_e state_d;

   always_comb begin
      state_d = state;
      unique case (state)
         S_IDLE:     if (req_valid)     state_d = S_DIR_REQ;
         S_DIR_REQ:  if (mem_req_ready) state_d = S_DIR_WAIT;
         S_DIR_WAIT: if (mem_rsp_valid) state_d = rsp_entry_ok ? S_PTE_REQ : S_DONE;
         S_PTE_REQ:  if (mem_req_ready) state_d = S_PTE_WAIT;
         S_PTE_WAIT: if (mem_rsp_valid) state_d = S_DONE;
         S_DONE:                        state_d = S_IDLE;
         default:                       state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= S_IDLE;
      else        state <= state_d;
   end

   p_legal_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
      state inside {S_IDLE, S_DIR_REQ, S_DIR_WAIT, S_PTE_REQ, S_PTE_WAIT, S_DONE});

   p_done_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_DONE |=> state == S_IDLE);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pgw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DIR_IDX_W = 10,
   parameter int TBL_IDX_W = 10,
   parameter int OFF_W     = 12,
   parameter int ENT_BYTES = 4,
   parameter int VALID_BIT = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [ADDR_W-1:0]       req_vaddr,
   input  logic [ADDR_W-1:0]       root_base,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic [ADDR_W-1:0]       mem_req_addr,
   input  logic                    mem_rsp_valid,
   input  logic [ADDR_W-1:0]       mem_rsp_data,
   output logic                    busy,
   output logic                    done,
   output logic                    done_fault,
   output logic [ADDR_W-OFF_W-1:0] done_pfn,
   output logic [ADDR_W-1:0]       done_paddr
);
   localparam int FRAME_W  = ADDR_W - OFF_W;
   localparam int TBL_LO   = OFF_W;
   localparam int DIR_LO   = OFF_W + TBL_IDX_W;
   localparam int N_LEVELS = 2;

   generate
      if (DIR_IDX_W + TBL_IDX_W + OFF_W != ADDR_W) begin : g_bad_split
         $error("pt_walker: index and offset widths must add up to ADDR_W");
      end
      if (VALID_BIT >= OFF_W) begin : g_bad_valid
         $error("pt_walker: valid bit must lie below the frame field");
      end
      if ((ENT_BYTES << TBL_IDX_W) > (1 << OFF_W)) begin : g_bad_fit
         $error("pt_walker: a table must fit in one page");
      end
   endgenerate

   pgw_state_e         state;
   logic [ADDR_W-1:0]  va_q;
   logic [ADDR_W-1:0]  root_q;
   logic [FRAME_W-1:0] tbase_q;
   logic [FRAME_W-1:0] pfn_q;
   logic               fault_q;
   logic               accept;
   logic               entry_ok;

   assign accept   = req_valid && (state == S_IDLE);
   assign entry_ok = mem_rsp_data[VALID_BIT];

   pgw_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .rsp_entry_ok  (entry_ok),
      .state         (state)
   );

   // Per-level base and index, then one address generator per level.
   logic [ADDR_W-1:0] lvl_base [N_LEVELS];
   logic [ADDR_W-1:0] lvl_addr [N_LEVELS];
   logic [DIR_IDX_W-1:0] dir_idx;
   logic [TBL_IDX_W-1:0] tbl_idx;

   assign dir_idx     = va_q[ADDR_W-1:DIR_LO];
   assign tbl_idx     = va_q[DIR_LO-1:TBL_LO];
   assign lvl_base[0] = root_q;
   assign lvl_base[1] = {tbase_q, {OFF_W{1'b0}}};

   generate
      for (genvar l = 0; l < N_LEVELS; l++) begin : g_lvl
         localparam int IW = (l == 0) ? DIR_IDX_W : TBL_IDX_W;
         logic [IW-1:0] idx_l;
         if (l == 0) begin : g_dir
            assign idx_l = IW'(dir_idx);
         end else begin : g_tbl
            assign idx_l = IW'(tbl_idx);
         end
         pgw_entry_addr #(
            .ADDR_W    (ADDR_W),
            .OFF_W     (OFF_W),
            .IDX_W     (IW),
            .ENT_BYTES (ENT_BYTES)
         ) u_ea (
            .base (lvl_base[l]),
            .idx  (idx_l),
            .addr (lvl_addr[l])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_q    <= '0;
         root_q  <= '0;
         tbase_q <= '0;
         pfn_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         if (accept) begin
            va_q    <= req_vaddr;
            root_q  <= root_base;
            pfn_q   <= '0;
            fault_q <= 1'b0;
         end
         if (state == S_DIR_WAIT && mem_rsp_valid) begin
            if (entry_ok) tbase_q <= mem_rsp_data[ADDR_W-1:OFF_W];
            else          fault_q <= 1'b1;
         end
         if (state == S_PTE_WAIT && mem_rsp_valid) begin
            if (entry_ok) pfn_q   <= mem_rsp_data[ADDR_W-1:OFF_W];
            else          fault_q <= 1'b1;
         end
      end
   end

   assign req_ready     = (state == S_IDLE);
   assign busy          = (state != S_IDLE);
   assign mem_req_valid = (state == S_DIR_REQ) || (state == S_PTE_REQ);
   assign mem_req_addr  = (state == S_PTE_REQ) ? lvl_addr[1] : lvl_addr[0];
   assign done          = (state == S_DONE);
   assign done_fault    = done && fault_q;
   assign done_pfn      = (done && !fault_q) ? pfn_q : '0;
   assign done_paddr    = (done && !fault_q) ? {pfn_q, va_q[OFF_W-1:0]} : '0;

   // Assertions
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> busy && !req_ready && mem_req_valid);

   p_dir_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DIR_WAIT) && mem_rsp_valid && !mem_rsp_data[VALID_BIT]
      |=> done && done_fault && !mem_req_valid);

   p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_fault |-> (done_paddr == '0) && (done_pfn == '0));

   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   p_va_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> $stable(va_q) && $stable(root_q));

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy && req_ready);

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] root_base = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        busy, done, done_fault;
   logic [19:0] done_pfn;
   logic [31:0] done_paddr;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .root_base(root_base),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .busy(busy), .done(done), .done_fault(done_fault),
      .done_pfn(done_pfn), .done_paddr(done_paddr)
   );

   // Memory model
   logic [31:0] mem_arr [logic [31:0]];

   function automatic logic [31:0] mem_rd(input logic [31:0] a);
      return mem_arr.exists(a) ? mem_arr[a] : 32'h0;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Responder: one response per accepted read, random latency and ready
   bit          rand_ready = 0;
   bit          junk_en    = 0;
   bit          rsp_pending = 0;
   int          dly = 0;
   logic [31:0] pend_addr = '0;
   logic [31:0] rd_log [4];
   int          rd_cnt = 0;
   bit          hold_chk = 0;
   logic [31:0] hold_addr = '0;

   always @(negedge clk) begin
      cycles++;
      if (!rst_n) begin
         rsp_pending   = 0;
         mem_rsp_valid = 1'b0;
         mem_req_ready = 1'b0;
         hold_chk      = 0;
      end else begin
         if (hold_chk)   // R8
            check(mem_req_valid && (mem_req_addr == hold_addr), "R8",
                  "request held while stalled", mem_req_addr, hold_addr);
         if (rsp_pending) begin
            if (dly == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = mem_rd(pend_addr);
               rsp_pending   = 0;
            end else begin
               dly--;
               mem_rsp_valid = 1'b0;
               mem_rsp_data  = $urandom;
            end
         end else begin
            mem_rsp_valid = junk_en && ($urandom % 3 == 0);
            mem_rsp_data  = $urandom;
         end
         mem_req_ready = rand_ready ? 1'($urandom % 2) : 1'b1;
         if (!rsp_pending && mem_req_valid && mem_req_ready) begin
            if (rd_cnt < 4) rd_log[rd_cnt] = mem_req_addr;
            rd_cnt++;
            pend_addr   = mem_req_addr;
            rsp_pending = 1;
            dly         = rand_ready ? int'($urandom % 4) : 0;
         end
         hold_chk  = mem_req_valid && !mem_req_ready;
         hold_addr = mem_req_addr;
      end
   end

   // Full walk with expected values computed from the requirements
   task automatic do_walk(input logic [31:0] va, input logic [31:0] root,
                          input bit disturb);
      logic [31:0] dir_a, de, pte_a, pte, exp_pa;
      logic [19:0] exp_pfn;
      bit          exp_fault;
      int          exp_reads, t;
      dir_a = {root[31:12], va[31:22], 2'b00};
      de    = mem_rd(dir_a);
      pte_a = {de[31:12], va[21:12], 2'b00};
      pte   = mem_rd(pte_a);
      if (!de[0]) begin
         exp_fault = 1; exp_reads = 1;
      end else begin
         exp_fault = !pte[0]; exp_reads = 2;
      end
      exp_pfn = exp_fault ? 20'h0 : pte[31:12];
      exp_pa  = exp_fault ? 32'h0 : {pte[31:12], va[11:0]};

      @(negedge clk);
      check(req_ready === 1'b1, "R2", "ready before request", {31'h0, req_ready}, 32'h1);
      rd_cnt    = 0;
      req_valid = 1'b1;
      req_vaddr = va;
      root_base = root;
      @(negedge clk);                 // accepted at the edge in between
      check(busy === 1'b1, "R10", "busy after accept", {31'h0, busy}, 32'h1);
      if (disturb) begin              // R9 and R2: input changes during the walk
         req_vaddr = $urandom;
         root_base = $urandom;
         req_valid = 1'b1;
         @(negedge clk);
         check(busy === 1'b1, "R10", "busy mid walk", {31'h0, busy}, 32'h1);
      end
      req_valid = 1'b0;
      t = 0;
      while (done !== 1'b1 && t < 200) begin
         check(busy === 1'b1, "R10", "busy until done", {31'h0, busy}, 32'h1);
         @(negedge clk);
         t++;
      end
      check(done === 1'b1, "R10", "walk completes", {31'h0, done}, 32'h1);
      check(busy === 1'b1, "R10", "busy in done cycle", {31'h0, busy}, 32'h1);
      check(done_fault === exp_fault, exp_reads == 1 ? "R5" : "R6",
            "fault flag", {31'h0, done_fault}, {31'h0, exp_fault});
      check(done_pfn === exp_pfn, exp_fault ? "R6" : "R7", "frame number",
            {12'h0, done_pfn}, {12'h0, exp_pfn});
      check(done_paddr === exp_pa, exp_fault ? "R6" : "R7", "physical address",
            done_paddr, exp_pa);
      check(rd_log[0] === dir_a, "R3", "directory read address", rd_log[0], dir_a);
      if (exp_reads == 2)
         check(rd_log[1] === pte_a, "R4", "table read address", rd_log[1], pte_a);
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0 && req_ready === 1'b1, "R10",
            "single done pulse then idle", {29'h0, done, busy, req_ready}, 32'h1);
      repeat (3) @(negedge clk);
      check(rd_cnt == exp_reads && !mem_req_valid, "R5", "read count, no stray reads",
            32'(rd_cnt), 32'(exp_reads));
   endtask

   // Fill memory for one random walk
   task automatic rand_walk(input bit disturb);
      logic [31:0] va, root, dir_a, de, pte_a;
      va    = $urandom;
      root  = $urandom;
      dir_a = {root[31:12], va[31:22], 2'b00};
      de    = $urandom;
      de[0] = ($urandom % 5 != 0);
      mem_arr[dir_a] = de;
      pte_a = {de[31:12], va[21:12], 2'b00};
      mem_arr[pte_a] = {$urandom} & ((($urandom % 4) == 0) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF)
                       | (($urandom % 4) == 0 ? 32'h0 : 32'h1);
      do_walk(va, root, disturb);
   endtask

   initial begin : watchdog
      wait (cycles > WATCHDOG);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(req_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0,
            "R1", "reset state", {28'h0, req_ready, busy, done, mem_req_valid}, 32'h8);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!mem_req_valid && req_ready, "R1", "idle after reset",
            {30'h0, mem_req_valid, req_ready}, 32'h1);

      // R7: worked example 0x00403004 -> dir 1, table 3, offset 4
      mem_arr[32'h0001_0004] = 32'h0002_0001;
      mem_arr[32'h0002_000C] = 32'h0ABC_D001;
      do_walk(32'h0040_3004, 32'h0001_0000, 0);
      // R5: invalid directory entry, bits above bit 0 nonzero
      mem_arr[32'h0005_0000] = 32'h0007_7FFE;
      do_walk(32'h0000_0123, 32'h0005_0000, 0);
      // R6: invalid page table entry
      mem_arr[32'h0006_0FFC] = 32'h0008_0001;
      mem_arr[32'h0008_0FFC] = 32'hFFFF_F000;
      do_walk(32'hFFFF_FABC, 32'h0006_0123, 0);
      // R9 and R2: inputs change and extra request during a walk
      do_walk(32'h0040_3FFF, 32'h0001_0000, 1);

      // R8 and R11: random stalls, latency and stray responses
      rand_ready = 1;
      junk_en    = 1;
      for (int i = 0; i < 60; i++) rand_walk(i % 3 == 0);
      rand_ready = 0;
      junk_en    = 0;
      for (int i = 0; i < 20; i++) rand_walk(0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule